// File: doc/BRIEF.md
# Concatenable Dual Interval Timer

The block contains two interval counters, A and B. They can run as a pair of independent 16-bit counters, or A alone can act as one 32-bit counter. Each counter counts down or up and runs either once (one-shot) or continuously (periodic). In split mode, an 8-bit prescaler in front of each counter stretches its step interval. A match comparator raises a flag when the counter steps onto a programmed value, and a timeout flag is raised at terminal count.

Software uses a simple register write/read port. Configuration is written while the counters are stopped. A counter then starts when its enable bit is set. Four interrupt sources keep sticky raw flags. A mask selects which of them drive the single interrupt line, and writing ones to a clear register removes flags. A debug-halt input freezes any counter whose stall option is set.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register reads zero, both counters are stopped and `irq` is low.
- R2: With CFG (address 0) bit 0 set, counter A is 32 bits wide and steps on every clock while enabled. The A prescale value has no effect in this mode.
- R3: In full-width mode, counter B never steps and never raises an interrupt flag (raw bits 2 and 3), whatever MODE_B or the B enable hold.
- R4: In split mode each counter is 16 bits wide and steps once every PRE+1 enabled clocks. PRE_A is at address 10 and PRE_B at address 11.
- R5: A down counter (MODE bit 1 = 0) decrements. A step taken at 0 raises its timeout flag and, if periodic (MODE bit 0 = 1), reloads the LOAD value.
- R6: An up counter (MODE bit 1 = 1) increments. A step taken at the LOAD value raises its timeout flag and, if periodic, wraps to 0.
- R7: A one-shot counter (MODE bit 0 = 0) raises its timeout flag at terminal count, clears its own enable bit and then holds its value.
- R8: Writing LOAD while the counter is enabled replaces the count at once: with the new load value when counting down, with 0 when counting up.
- R9: A write to CFG clears both enable bits (CTRL bits 0 and 2).
- R10: With a lane's stall bit set (CTRL bit 1 for A, bit 3 for B) and `dbg_halt` high, that counter and its prescaler freeze. With the stall bit clear, the counter keeps running.
- R11: A step that lands on the lane's MATCH value sets the match flag: raw bit 1 for A, bit 3 for B.
- R12: Raw flags (address 13) are sticky: bit 0 is A timeout, bit 2 is B timeout. The masked status (address 14) is raw AND mask (address 12), and `irq` is the OR of the masked status. Writing ones to address 15 clears those raw bits, but a new event in the same cycle wins.
- R13: Writing VAL_A (address 6) or VAL_B (address 7) sets the count directly and restarts that lane's prescaler. Reading the same address returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt, OR of masked flags |

## Verification
A wrong count, reload or wrap shows up in the value read back through VAL_A or VAL_B on the very next read. It therefore becomes visible one step after the fault, which may be PRE+1 clocks away. A bad enable or one-shot clear shows up in CTRL in the same way. A bad enable also makes later reads of the count drift, so the closed-form expectations catch it many steps later. A fault in the flag logic appears at once on `irq` and in the status registers. A leak between lanes in full-width mode shows up as a change in B's count or B's flags.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int HW   = 16;
    localparam int FW   = 2 * HW;
    localparam int PW   = 8;
    localparam int AW   = 4;
    localparam int NIRQ = 4;

    localparam logic [AW-1:0] ADR_CFG    = 4'd0;
    localparam logic [AW-1:0] ADR_CTRL   = 4'd1;
    localparam logic [AW-1:0] ADR_MODE_A = 4'd2;
    localparam logic [AW-1:0] ADR_MODE_B = 4'd3;
    localparam logic [AW-1:0] ADR_LOAD_A = 4'd4;
    localparam logic [AW-1:0] ADR_LOAD_B = 4'd5;
    localparam logic [AW-1:0] ADR_VAL_A  = 4'd6;
    localparam logic [AW-1:0] ADR_VAL_B  = 4'd7;
    localparam logic [AW-1:0] ADR_MAT_A  = 4'd8;
    localparam logic [AW-1:0] ADR_MAT_B  = 4'd9;
    localparam logic [AW-1:0] ADR_PRE_A  = 4'd10;
    localparam logic [AW-1:0] ADR_PRE_B  = 4'd11;
    localparam logic [AW-1:0] ADR_IMASK  = 4'd12;
    localparam logic [AW-1:0] ADR_IRAW   = 4'd13;
    localparam logic [AW-1:0] ADR_IMIS   = 4'd14;
    localparam logic [AW-1:0] ADR_ICLR   = 4'd15;

    typedef struct packed {
        logic up;
        logic periodic;
    } lane_mode_t;

    typedef struct packed {
        logic            full;
        logic            en_a;
        logic            stall_a;
        logic            en_b;
        logic            stall_b;
        lane_mode_t      mode_a;
        lane_mode_t      mode_b;
        logic [FW-1:0]   load_a;
        logic [FW-1:0]   match_a;
        logic [FW-1:0]   cnt_a;
        logic [HW-1:0]   load_b;
        logic [HW-1:0]   match_b;
        logic [HW-1:0]   cnt_b;
        logic [PW-1:0]   pre_a;
        logic [PW-1:0]   pre_b;
        logic [PW-1:0]   ps_a;
        logic [PW-1:0]   ps_b;
        logic [NIRQ-1:0] raw;
        logic [NIRQ-1:0] mask;
    } tmr_state_t;
endpackage

// File: rtl/dit_prescale.sv
module dit_prescale #(
    parameter int PW = 8
) (
    input  logic          run,
    input  logic          bypass,
    input  logic [PW-1:0] pre,
    input  logic [PW-1:0] ps,
    output logic          tick,
    output logic [PW-1:0] ps_nxt
);
    always_comb begin
        tick   = run && (bypass || (ps == pre));
        ps_nxt = ps;
        if (run && !bypass) begin
            ps_nxt = tick ? '0 : ps + 1'b1;
        end
    end
endmodule

// File: rtl/dit_lane.sv
module dit_lane #(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  logic         wide,
    input  logic         step,
    input  logic         periodic,
    input  logic         up,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] load,
    input  logic [W-1:0] match,
    output logic [W-1:0] nxt,
    output logic         timeout,
    output logic         hit
);
    localparam logic [W-1:0] HMASK = {W{1'b1}} >> (W - HW);

    logic [W-1:0] m;
    logic [W-1:0] c;
    logic [W-1:0] l;
    logic         term;

    always_comb begin
        m    = wide ? {W{1'b1}} : HMASK;
        c    = cur & m;
        l    = load & m;
        term = up ? (c == l) : (c == '0);
        if (!step) begin
            nxt = c;
        end else if (term) begin
            nxt = periodic ? (up ? '0 : l) : c;
        end else begin
            nxt = up ? c + 1'b1 : c - 1'b1;
        end
        nxt     = nxt & m;
        timeout = step && term;
        hit     = step && (nxt == (match & m));
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [FW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [FW-1:0] rd_data,
    input  logic          dbg_halt,
    output logic          irq
);
    localparam logic [FW-1:0] HALF_MASK = {{HW{1'b0}}, {HW{1'b1}}};

    tmr_state_t s_d, s_q;

    logic          run_a, run_b, tick_a, tick_b;
    logic [PW-1:0] psn_a, psn_b;
    logic [FW-1:0] nxt_a;
    logic [HW-1:0] nxt_b;
    logic          to_a, to_b, hit_a, hit_b;
    logic [FW-1:0] amask;
    logic [NIRQ-1:0] ev;

    assign run_a = s_q.en_a && !(s_q.stall_a && dbg_halt);
    assign run_b = s_q.en_b && !s_q.full && !(s_q.stall_b && dbg_halt);

    dit_prescale #(.PW(PW)) u_ps_a (
        .run(run_a), .bypass(s_q.full), .pre(s_q.pre_a), .ps(s_q.ps_a),
        .tick(tick_a), .ps_nxt(psn_a)
    );

    dit_prescale #(.PW(PW)) u_ps_b (
        .run(run_b), .bypass(1'b0), .pre(s_q.pre_b), .ps(s_q.ps_b),
        .tick(tick_b), .ps_nxt(psn_b)
    );

    dit_lane #(.W(FW), .HW(HW)) u_lane_a (
        .wide(s_q.full), .step(tick_a),
        .periodic(s_q.mode_a.periodic), .up(s_q.mode_a.up),
        .cur(s_q.cnt_a), .load(s_q.load_a), .match(s_q.match_a),
        .nxt(nxt_a), .timeout(to_a), .hit(hit_a)
    );

    dit_lane #(.W(HW), .HW(HW)) u_lane_b (
        .wide(1'b1), .step(tick_b),
        .periodic(s_q.mode_b.periodic), .up(s_q.mode_b.up),
        .cur(s_q.cnt_b), .load(s_q.load_b), .match(s_q.match_b),
        .nxt(nxt_b), .timeout(to_b), .hit(hit_b)
    );

    always_comb begin
        amask = s_q.full ? {FW{1'b1}} : HALF_MASK;
        ev    = {hit_b, to_b, hit_a, to_a};

        s_d       = s_q;
        s_d.cnt_a = nxt_a;
        s_d.cnt_b = nxt_b;
        s_d.ps_a  = psn_a;
        s_d.ps_b  = psn_b;
        s_d.raw   = s_q.raw | ev;
        if (to_a && !s_q.mode_a.periodic) s_d.en_a = 1'b0;
        if (to_b && !s_q.mode_b.periodic) s_d.en_b = 1'b0;

        if (wr_en) begin
            case (wr_addr)
                ADR_CFG: begin
                    s_d.full = wr_data[0];
                    s_d.en_a = 1'b0;
                    s_d.en_b = 1'b0;
                    s_d.ps_a = '0;
                    s_d.ps_b = '0;
                end
                ADR_CTRL: begin
                    s_d.en_a    = wr_data[0];
                    s_d.stall_a = wr_data[1];
                    s_d.en_b    = wr_data[2];
                    s_d.stall_b = wr_data[3];
                end
                ADR_MODE_A: s_d.mode_a = '{up: wr_data[1], periodic: wr_data[0]};
                ADR_MODE_B: s_d.mode_b = '{up: wr_data[1], periodic: wr_data[0]};
                ADR_LOAD_A: begin
                    s_d.load_a = wr_data;
                    if (s_q.en_a) begin
                        s_d.cnt_a = s_q.mode_a.up ? '0 : (wr_data & amask);
                        s_d.ps_a  = '0;
                    end
                end
                ADR_LOAD_B: begin
                    s_d.load_b = wr_data[HW-1:0];
                    if (s_q.en_b && !s_q.full) begin
                        s_d.cnt_b = s_q.mode_b.up ? '0 : wr_data[HW-1:0];
                        s_d.ps_b  = '0;
                    end
                end
                ADR_VAL_A: begin
                    s_d.cnt_a = wr_data & amask;
                    s_d.ps_a  = '0;
                end
                ADR_VAL_B: begin
                    s_d.cnt_b = wr_data[HW-1:0];
                    s_d.ps_b  = '0;
                end
                ADR_MAT_A: s_d.match_a = wr_data;
                ADR_MAT_B: s_d.match_b = wr_data[HW-1:0];
                ADR_PRE_A: s_d.pre_a   = wr_data[PW-1:0];
                ADR_PRE_B: s_d.pre_b   = wr_data[PW-1:0];
                ADR_IMASK: s_d.mask    = wr_data[NIRQ-1:0];
                ADR_ICLR:  s_d.raw     = (s_q.raw & ~wr_data[NIRQ-1:0]) | ev;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CFG:    rd_data = FW'(s_q.full);
            ADR_CTRL:   rd_data = FW'({s_q.stall_b, s_q.en_b, s_q.stall_a, s_q.en_a});
            ADR_MODE_A: rd_data = FW'({s_q.mode_a.up, s_q.mode_a.periodic});
            ADR_MODE_B: rd_data = FW'({s_q.mode_b.up, s_q.mode_b.periodic});
            ADR_LOAD_A: rd_data = s_q.load_a;
            ADR_LOAD_B: rd_data = FW'(s_q.load_b);
            ADR_VAL_A:  rd_data = s_q.cnt_a;
            ADR_VAL_B:  rd_data = FW'(s_q.cnt_b);
            ADR_MAT_A:  rd_data = s_q.match_a;
            ADR_MAT_B:  rd_data = FW'(s_q.match_b);
            ADR_PRE_A:  rd_data = FW'(s_q.pre_a);
            ADR_PRE_B:  rd_data = FW'(s_q.pre_b);
            ADR_IMASK:  rd_data = FW'(s_q.mask);
            ADR_IRAW:   rd_data = FW'(s_q.raw);
            ADR_IMIS:   rd_data = FW'(s_q.raw & s_q.mask);
            default:    rd_data = '0;
        endcase
    end

    assign irq = |(s_q.raw & s_q.mask);
endmodule

// File: rtl/dit_checker.sv
module dit_checker
    import dit_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          dbg_halt,
    input logic          irq,
    input tmr_state_t    st
);
    AST_CFG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CFG) |=> (!st.en_a && !st.en_b)); // R9

    AST_FULL_B_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st.full && !(wr_en && (wr_addr == ADR_VAL_B || wr_addr == ADR_CFG)))
        |=> $stable(st.cnt_b)); // R3

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && st.stall_a && !wr_en) |=> $stable(st.cnt_a)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.en_a && !wr_en) |=> $stable(st.cnt_a)); // R7

    AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st.raw[0]) && !$past(st.mode_a.periodic) && !$past(wr_en))
        |-> !st.en_a); // R7

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_ICLR) |=> ((st.raw & $past(st.raw)) == $past(st.raw))); // R12

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mask == '0) |-> !irq); // R12
endmodule

bind dual_interval_timer dit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .dbg_halt(dbg_halt), .irq(irq), .st(s_q)
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_down(int v, int l, int s);
        if (s <= v) return v - s;
        return l - ((s - v - 1) % (l + 1));
    endfunction

    function automatic int exp_up(int v, int l, int s);
        if (s <= l - v) return v + s;
        return (s - (l - v) - 1) % (l + 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd1, v);  chk("R1 ctrl", v, 0);
        rd(4'd6, v);  chk("R1 val_a", v, 0);
        rd(4'd13, v); chk("R1 raw", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 full width, prescale ignored, borrow across 16-bit boundary
        wr(4'd0, 32'd1);
        wr(4'd10, 32'd5);
        wr(4'd2, 32'd1);
        wr(4'd4, 32'h0001_0005);
        wr(4'd6, 32'h0001_0001);
        wr(4'd1, 32'd1);
        run(3);
        rd(4'd6, v); chk("R2 full count", v, 32'h0000_FFFE);

        // R3 B ignored in full width
        wr(4'd3, 32'd3);
        wr(4'd5, 32'd9);
        wr(4'd7, 32'd7);
        wr(4'd9, 32'd8);
        wr(4'd1, 32'd5);
        run(12);
        rd(4'd7, v);  chk("R3 b frozen", v, 7);
        rd(4'd13, v); chk("R3 b flags", v & 32'hC, 0);

        // R9 CFG write stops both
        wr(4'd0, 32'd0);
        rd(4'd1, v); chk("R9 enables cleared", v & 32'h5, 0);

        // R7 one-shot down
        wr(4'd15, 32'hF);
        wr(4'd10, 32'd0);
        wr(4'd2, 32'd0);
        wr(4'd8, 32'hFFFF);
        wr(4'd6, 32'd3);
        wr(4'd1, 32'd1);
        run(3);
        rd(4'd13, v); chk("R7 no flag yet", v & 1, 0);
        rd(4'd1, v);  chk("R7 still enabled", v & 1, 1);
        run(1);
        rd(4'd13, v); chk("R7 timeout flag", v & 1, 1);
        rd(4'd1, v);  chk("R7 enable cleared", v & 1, 0);
        run(5);
        rd(4'd6, v);  chk("R7 holds", v, 0);

        // R12 mask, status, clear
        chk("R12 irq masked", {31'b0, irq}, 0);
        rd(4'd14, v); chk("R12 mis masked", v, 0);
        wr(4'd12, 32'd1);
        chk("R12 irq on", {31'b0, irq}, 1);
        rd(4'd14, v); chk("R12 mis", v, 1);
        wr(4'd15, 32'd1);
        rd(4'd13, v); chk("R12 cleared", v, 0);
        chk("R12 irq off", {31'b0, irq}, 0);
        wr(4'd12, 32'd0);

        // R11 match
        wr(4'd2, 32'd1);
        wr(4'd4, 32'd50);
        wr(4'd8, 32'd6);
        wr(4'd6, 32'd10);
        wr(4'd1, 32'd1);
        run(3);
        rd(4'd13, v); chk("R11 before match", v & 2, 0);
        run(1);
        rd(4'd13, v); chk("R11 match flag", v & 2, 2);
        wr(4'd1, 32'd0);

        // R8 load write while running
        wr(4'd8, 32'hFFFF);
        wr(4'd6, 32'd20);
        wr(4'd1, 32'd1);
        run(2);
        rd(4'd6, v); chk("R13 val write then count", v, 18);
        wr(4'd4, 32'd100);
        rd(4'd6, v); chk("R8 down reload", v, 100);
        wr(4'd2, 32'd3);
        wr(4'd4, 32'd30);
        rd(4'd6, v); chk("R8 up restart", v, 0);
        wr(4'd1, 32'd0);

        // R10 stall
        wr(4'd2, 32'd1);
        wr(4'd4, 32'd200);
        wr(4'd6, 32'd50);
        wr(4'd1, 32'd3);
        dbg_halt = 1'b1;
        run(10);
        rd(4'd6, v); chk("R10 frozen", v, 50);
        dbg_halt = 1'b0;
        run(4);
        rd(4'd6, v); chk("R10 resumes", v, 46);
        wr(4'd1, 32'd1);
        dbg_halt = 1'b1;
        run(5);
        rd(4'd6, v); chk("R10 no stall runs", v, 40);
        dbg_halt = 1'b0;
        wr(4'd1, 32'd0);

        // R4 prescale directed
        wr(4'd10, 32'd3);
        wr(4'd6, 32'd40);
        wr(4'd1, 32'd1);
        run(11);
        rd(4'd6, v); chk("R4 prescale 2 steps", v, 38);
        run(1);
        rd(4'd6, v); chk("R4 prescale 3 steps", v, 37);
        wr(4'd1, 32'd0);

        // R5 random down periodic on lane B
        for (int i = 0; i < 20; i++) begin
            int l, s0, p, n, s;
            l  = $urandom_range(40, 0);
            s0 = $urandom_range(40, 0);
            p  = $urandom_range(3, 0);
            n  = $urandom_range(200, 0);
            s  = n / (p + 1);
            wr(4'd1, 32'd0);
            wr(4'd15, 32'hF);
            wr(4'd11, p);
            wr(4'd3, 32'd1);
            wr(4'd5, l);
            wr(4'd9, 32'hFFFF);
            wr(4'd7, s0);
            wr(4'd1, 32'd4);
            run(n);
            rd(4'd7, v);  chk("R5 down value", v, exp_down(s0, l, s));
            rd(4'd13, v); chk("R5 down timeout", v & 4, (s >= s0 + 1) ? 4 : 0);
        end

        // R6 random up periodic on lane A, split
        for (int i = 0; i < 20; i++) begin
            int l, s0, p, n, s;
            l  = $urandom_range(40, 0);
            s0 = $urandom_range(l, 0);
            p  = $urandom_range(3, 0);
            n  = $urandom_range(200, 0);
            s  = n / (p + 1);
            wr(4'd1, 32'd0);
            wr(4'd15, 32'hF);
            wr(4'd10, p);
            wr(4'd2, 32'd3);
            wr(4'd4, l);
            wr(4'd8, 32'hFFFF);
            wr(4'd6, s0);
            wr(4'd1, 32'd1);
            run(n);
            rd(4'd6, v);  chk("R6 up value", v, exp_up(s0, l, s));
            rd(4'd13, v); chk("R6 up timeout", v & 1, (s >= l - s0 + 1) ? 1 : 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule